// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts ticks of a slow, free-running oscillator. It runs separately from the fast system clock that carries its register port. Software controls it through one command register that takes 16-bit key words. One key opens the two configuration registers for writing. A second key starts the counter. A third key refreshes the counter and also closes the configuration registers again. If the down-counter runs out before software refreshes it, the block raises a one-cycle reset request. The counter then reloads and keeps running.

The timeout is (reload + 1) × divider slow ticks. The divider comes from a 3-bit prescaler code, and the reload value is 12 bits wide. A value written to either configuration register does not reach the counting logic at once. It is copied across after a fixed number of slow ticks, and a status bit for that register reads high until the copy is done. When a debug-freeze enable is set, a debug-halt input stops the prescaler and the counter while the halt is active.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the prescaler register (address 1) reads 0, the reload register (address 2) reads 0xFFF, the status register (address 3) reads 0, and no reset request is raised.
- R2: A write to address 1 or 2 while the configuration is locked leaves the value read back unchanged.
- R3: Writing key 0x5555 to address 0 unlocks the configuration. After that, address 1 stores bits [2:0] and address 2 stores bits [11:0], and both read back the stored value.
- R4: While the watchdog is stopped, any key other than 0x5555 and 0xCCCC has no effect: the lock state stays as it was and the counter does not start. While the watchdog is running, key 0xAAAA locks the configuration again.
- R5: Key 0xCCCC starts the watchdog, using the reload value and prescaler code that have already been transferred. The first reset request follows exactly (reload + 1) × divider slow ticks after the start.
- R6: Prescaler codes 0 through 6 divide by 4, 8, 16, 32, 64, 128 and 256. Code 7 also divides by 256.
- R7: The reset request is high for exactly one clock cycle. The counter then reloads, so without refreshes the requests repeat every (reload + 1) × divider ticks.
- R8: Key 0xAAAA, written while the watchdog is running, reloads the counter at the next prescaled tick. Refreshes written more often than the timeout period prevent any reset request.
- R9: A refresh accepted on the same clock edge as the final expiring tick suppresses that request. The next request comes (reload + 1) × divider ticks after that tick.
- R10: After an accepted write, status bit 0 (prescaler) or status bit 1 (reload) is high. It clears on the third slow tick after the write.
- R11: While the debug-freeze enable and the debug-halt input are both high, slow ticks do not advance the count. Halt alone, with the enable low, has no effect.
- R12: Once started, the watchdog cannot be stopped by any key, and key 0xCCCC written again does not restart it. Only reset stops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable marking each slow-oscillator tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 key, 1 prescaler, 2 reload |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address: 1 prescaler, 2 reload, 3 status |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| dbg_halt_i | input | 1 | The core is halted in debug |
| dbg_freeze_en_i | input | 1 | Enables freezing of the counter during a debug halt |
| rst_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
A refresh key and the expiry of the counter can land on the same clock edge, and the block has to settle that collision so that no reset request comes out. The bench provokes it by waiting until the slow-tick count is one short of a predicted expiry while a tick is due on the next edge, then writing the refresh key on exactly that edge. It judges the outcome in two ways: the predicted request must be missing from the scoreboard, and a new request must arrive one full period after the suppressed tick.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int          KEY_W      = 16;
  localparam logic [15:0] KEY_UNLOCK = 16'h5555;
  localparam logic [15:0] KEY_FEED   = 16'hAAAA;
  localparam logic [15:0] KEY_START  = 16'hCCCC;

  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_RLD  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int DIV_CODE_W = 3;
  localparam int PCNT_W     = 8;

  // Terminal count of the prescaler: divider minus one; code 7 repeats the largest divider.
  function automatic logic [PCNT_W-1:0] div_last(input logic [DIV_CODE_W-1:0] code);
    logic [PCNT_W-1:0] v;
    case (code)
      3'd0:    v = 8'd3;
      3'd1:    v = 8'd7;
      3'd2:    v = 8'd15;
      3'd3:    v = 8'd31;
      3'd4:    v = 8'd63;
      3'd5:    v = 8'd127;
      default: v = 8'd255;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/kwdt_shadow.sv
module kwdt_shadow #(
  parameter int             W       = 3,
  parameter int             TICKS   = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o,
  output logic [W-1:0] eff_o
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  eff_q, eff_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    eff_n  = eff_q;
    if (load_i) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q && tick_i) begin
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        eff_n  = val_i;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      eff_q  <= RST_VAL;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      eff_q  <= eff_n;
    end
  end

  assign busy_o = busy_q;
  assign eff_o  = eff_q;
endmodule

// File: rtl/kwdt_cfg.sv
module kwdt_cfg
  import kwdt_pkg::*;
#(
  parameter int RL_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_addr_i,
  input  logic [KEY_W-1:0]      wr_data_i,
  input  logic                  running_i,
  output logic                  unlocked_o,
  output logic                  start_o,
  output logic                  feed_o,
  output logic                  div_wr_o,
  output logic                  rld_wr_o,
  output logic [DIV_CODE_W-1:0] div_q_o,
  output logic [RL_W-1:0]       rld_q_o
);
  logic                  unl_q, unl_n;
  logic [DIV_CODE_W-1:0] div_q, div_n;
  logic [RL_W-1:0]       rld_q, rld_n;
  logic                  key_wr;

  assign key_wr   = wr_en_i && (wr_addr_i == ADDR_KEY);
  assign start_o  = key_wr && (wr_data_i == KEY_START) && !running_i;
  assign feed_o   = key_wr && (wr_data_i == KEY_FEED) && running_i;
  assign div_wr_o = wr_en_i && (wr_addr_i == ADDR_DIV) && unl_q;
  assign rld_wr_o = wr_en_i && (wr_addr_i == ADDR_RLD) && unl_q;

  always_comb begin
    unl_n = unl_q;
    div_n = div_q;
    rld_n = rld_q;
    if (key_wr && (wr_data_i == KEY_UNLOCK)) unl_n = 1'b1;
    else if (feed_o)                         unl_n = 1'b0;
    if (div_wr_o) div_n = wr_data_i[DIV_CODE_W-1:0];
    if (rld_wr_o) rld_n = wr_data_i[RL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
      div_q <= '0;
      rld_q <= '1;
    end else begin
      unl_q <= unl_n;
      div_q <= div_n;
      rld_q <= rld_n;
    end
  end

  assign unlocked_o = unl_q;
  assign div_q_o    = div_q;
  assign rld_q_o    = rld_q;
endmodule

// File: rtl/kwdt_presc.sv
module kwdt_presc
  import kwdt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  logic                  clr_i,
  input  logic [DIV_CODE_W-1:0] code_i,
  output logic                  ptick_o
);
  logic [PCNT_W-1:0] pcnt_q, pcnt_n;
  logic [PCNT_W-1:0] last;
  logic              wrap;

  assign last    = div_last(code_i);
  assign wrap    = (pcnt_q >= last);
  assign ptick_o = en_i && wrap && !clr_i;

  always_comb begin
    pcnt_n = pcnt_q;
    if (clr_i)      pcnt_n = '0;
    else if (en_i)  pcnt_n = wrap ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_n;
  end
endmodule

// File: rtl/kwdt_cnt.sv
module kwdt_cnt #(
  parameter int RL_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            feed_i,
  input  logic            ptick_i,
  input  logic [RL_W-1:0] rld_i,
  output logic            running_o,
  output logic            req_o,
  output logic [RL_W-1:0] cnt_o
);
  logic            run_q, run_n;
  logic            pend_q, pend_n;
  logic            req_q, req_n;
  logic [RL_W-1:0] cnt_q, cnt_n;

  always_comb begin
    run_n  = run_q;
    pend_n = pend_q;
    req_n  = 1'b0;
    cnt_n  = cnt_q;
    if (start_i) begin
      run_n  = 1'b1;
      pend_n = 1'b0;
      cnt_n  = rld_i;
    end else if (run_q) begin
      if (ptick_i) begin
        pend_n = 1'b0;
        if (feed_i || pend_q) begin
          cnt_n = rld_i;
        end else if (cnt_q == '0) begin
          req_n = 1'b1;
          cnt_n = rld_i;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end else if (feed_i) begin
        pend_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      cnt_q  <= '1;
    end else begin
      run_q  <= run_n;
      pend_q <= pend_n;
      req_q  <= req_n;
      cnt_q  <= cnt_n;
    end
  end

  assign running_o = run_q;
  assign req_o     = req_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int RL_W       = 12,
  parameter int BUSY_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [15:0] wr_data_i,
  input  logic [1:0]  rd_addr_i,
  output logic [15:0] rd_data_o,
  input  logic        dbg_halt_i,
  input  logic        dbg_freeze_en_i,
  output logic        rst_req_o
);
  logic                  running, unlocked, start_cmd, feed_cmd;
  logic                  div_wr, rld_wr, div_busy, rld_busy;
  logic                  frozen, ptick, count_en;
  logic [DIV_CODE_W-1:0] div_q, div_eff;
  logic [RL_W-1:0]       rld_q, rld_eff, cnt_q;

  assign frozen   = dbg_halt_i && dbg_freeze_en_i;
  assign count_en = running && tick_i && !frozen;

  kwdt_cfg #(.RL_W(RL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .running_i(running),
    .unlocked_o(unlocked), .start_o(start_cmd), .feed_o(feed_cmd),
    .div_wr_o(div_wr), .rld_wr_o(rld_wr),
    .div_q_o(div_q), .rld_q_o(rld_q)
  );

  kwdt_shadow #(.W(DIV_CODE_W), .TICKS(BUSY_TICKS), .RST_VAL('0)) u_div_sh (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(div_wr),
    .val_i(div_q), .busy_o(div_busy), .eff_o(div_eff)
  );

  kwdt_shadow #(.W(RL_W), .TICKS(BUSY_TICKS), .RST_VAL('1)) u_rld_sh (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(rld_wr),
    .val_i(rld_q), .busy_o(rld_busy), .eff_o(rld_eff)
  );

  kwdt_presc u_presc (
    .clk(clk), .rst_n(rst_n), .en_i(count_en), .clr_i(start_cmd),
    .code_i(div_eff), .ptick_o(ptick)
  );

  kwdt_cnt #(.RL_W(RL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start_i(start_cmd), .feed_i(feed_cmd),
    .ptick_i(ptick), .rld_i(rld_eff),
    .running_o(running), .req_o(rst_req_o), .cnt_o(cnt_q)
  );

  always_comb begin
    case (rd_addr_i)
      ADDR_DIV:  rd_data_o = 16'(div_q);
      ADDR_RLD:  rd_data_o = 16'(rld_q);
      ADDR_STAT: rd_data_o = {14'd0, rld_busy, div_busy};
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int RL_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en_i,
  input logic [1:0]      wr_addr_i,
  input logic            rst_req_o,
  input logic            running,
  input logic            unlocked,
  input logic            start_cmd,
  input logic            feed_cmd,
  input logic            frozen,
  input logic            div_busy,
  input logic [2:0]      div_q,
  input logic [RL_W-1:0] cnt_q
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !rst_req_o);

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  a_r9_feed_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    feed_cmd |=> !rst_req_o);

  a_r11_hold_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (running && frozen && !start_cmd) |=> $stable(cnt_q));

  a_r12_stays_running: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  a_r2_locked_div_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 2'd1 && !unlocked) |=> $stable(div_q));

  a_r10_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 2'd1 && unlocked) |=> div_busy);
endmodule

bind kwdt_top kwdt_chk #(.RL_W(RL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .rst_req_o(rst_req_o), .running(running), .unlocked(unlocked),
  .start_cmd(start_cmd), .feed_cmd(feed_cmd), .frozen(frozen),
  .div_busy(div_busy), .div_q(div_q), .cnt_q(cnt_q)
);

// File: tb/sim_kwdt_top.sv
module sim_kwdt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        halt = 1'b0;
  logic        fen = 1'b0;
  logic        rst_req;
  logic        tick;
  logic [31:0] cyc = 32'd0;
  int          tk = 0;
  int          nchk = 0;
  int          nerr = 0;
  logic        prev_req = 1'b0;

  typedef struct { int at; string req; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick = (cyc[1:0] == 2'd2);
  always @(posedge clk) if (tick && !(halt && fen)) tk <= tk + 1;

  kwdt_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .dbg_halt_i(halt), .dbg_freeze_en_i(fen),
    .rst_req_o(rst_req)
  );

  task automatic check(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
  endtask

  // Monitor: pops expected request ticks as requests appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req && prev_req) check("R7 width", 2, 1);
      if (rst_req) begin
        if (exp_q.size() == 0) check("R7 unexpected request at tick", tk, -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.req, tk, e.at);
        end
      end
      prev_req = rst_req;
    end else prev_req = 1'b0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog run completion", 0, 1);
    report();
    $finish;
  end

  task automatic push(input int at, input string req);
    exp_t e;
    e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    while (tick) @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_key_on_tick(input int tgt, input logic [15:0] d);
    @(negedge clk);
    while (!(tk == tgt && tick)) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1 v = int'(rd_data);
  endtask

  task automatic wait_tk(input int n);
    while (tk < n) @(negedge clk);
  endtask

  task automatic do_reset();
    check("R7 queue drained before reset", exp_q.size(), 0);
    @(negedge clk);
    rst_n = 1'b0; halt = 1'b0; fen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic config_wd(input int code, input int rl);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'(code));
    wr(2'd2, 16'(rl));
    wait_tk(tk + 4);
  endtask

  initial begin
    int v, st, f, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd1, v); check("R1 prescaler reset", v, 0);
    rd(2'd2, v); check("R1 reload reset", v, 'hFFF);
    rd(2'd3, v); check("R1 status reset", v, 0);

    // R2 locked writes ignored
    wr(2'd1, 16'd5);     rd(2'd1, v); check("R2 locked prescaler", v, 0);
    wr(2'd2, 16'h0123);  rd(2'd2, v); check("R2 locked reload", v, 'hFFF);

    // R3 unlock and R10 busy flags
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd1);
    st = tk;
    rd(2'd3, v); check("R10 prescaler busy set", v & 1, 1);
    rd(2'd1, v); check("R3 prescaler stored", v, 1);
    wait_tk(st + 2); rd(2'd3, v); check("R10 busy after 2 ticks", v & 1, 1);
    wait_tk(st + 3); rd(2'd3, v); check("R10 busy clear after 3 ticks", v & 1, 0);
    wr(2'd2, 16'hF003);
    st = tk;
    rd(2'd3, v); check("R10 reload busy set", (v >> 1) & 1, 1);
    rd(2'd2, v); check("R3 reload stored 12 bits", v, 3);
    wait_tk(st + 3); rd(2'd3, v); check("R10 reload busy clear", v, 0);

    // R4 other keys while stopped: no start, still unlocked
    wr(2'd0, 16'hAAAA);
    wr(2'd0, 16'h1234);
    wait_tk(tk + 80);
    check("R4 no request while stopped", exp_q.size(), 0);
    wr(2'd2, 16'd3); rd(2'd2, v); check("R4 still unlocked", v, 3);
    wait_tk(tk + 4);

    // R5 start, R7 periodic; period = (3+1)*8 = 32 ticks
    wr(2'd0, 16'hCCCC);
    st = tk;
    push(st + 32, "R5 first timeout");
    push(st + 64, "R7 periodic timeout");
    wait_tk(st + 65);
    check("R7 both requests seen", exp_q.size(), 0);

    // R12 keys while running do not stop or restart
    push(st + 96, "R12 still running");
    wr(2'd0, 16'h1234);
    wr(2'd0, 16'hCCCC);
    wait_tk(st + 97);
    check("R12 request kept", exp_q.size(), 0);

    // R8 periodic refresh prevents requests
    f = tk;
    for (int i = 0; i < 5; i++) begin
      wr(2'd0, 16'hAAAA);
      f = tk;
      wait_tk(f + 16);
    end
    p = st + 8 * ((f - st) / 8 + 1);
    // R4 refresh relocked the configuration
    wr(2'd2, 16'd5); rd(2'd2, v); check("R4 relocked by refresh", v, 3);
    push(p + 32, "R8 timeout after last refresh");
    wait_tk(p + 33);
    check("R8 request seen", exp_q.size(), 0);

    // R9 refresh on the expiring edge
    wr_key_on_tick(p + 63, 16'hAAAA);
    push(p + 96, "R9 next request after collision");
    wait_tk(p + 65);
    check("R9 no request at collision", exp_q.size(), 1);
    wait_tk(p + 97);
    check("R9 later request seen", exp_q.size(), 0);

    // R12 only reset stops it
    do_reset();
    wait_tk(tk + 100);
    check("R12 reset stopped counter", exp_q.size(), 0);

    // R11 freeze: div 4, reload 3 -> 16 ticks
    config_wd(0, 3);
    fen = 1'b1;
    wr(2'd0, 16'hCCCC);
    st = tk;
    push(st + 16, "R11 frozen period");
    wait_tk(st + 6);
    @(negedge clk); halt = 1'b1;
    repeat (40) @(negedge clk);
    halt = 1'b0;
    wait_tk(st + 17);
    check("R11 frozen request seen", exp_q.size(), 0);
    fen = 1'b0; halt = 1'b1;
    push(st + 32, "R11 halt without enable");
    wait_tk(st + 33);
    halt = 1'b0;
    check("R11 unfrozen request seen", exp_q.size(), 0);

    // R6 code 7 divides by 256
    do_reset();
    config_wd(7, 0);
    wr(2'd0, 16'hCCCC);
    st = tk;
    push(st + 256, "R6 code 7 divider");
    wait_tk(st + 257);

    // R6 code 2 divides by 16
    do_reset();
    config_wd(2, 1);
    wr(2'd0, 16'hCCCC);
    st = tk;
    push(st + 32, "R6 code 2 divider");
    wait_tk(st + 33);
    check("R6 requests seen", exp_q.size(), 0);

    report();
    $finish;
  end
endmodule